// File: doc/BRIEF.md
# Banked Pin Configuration Register File

This block holds the configuration of a group of general-purpose pins and turns it into pad controls. A byte-wide register bus reaches the block through an address, write data, a write strobe, a read strobe and read data. Each pin owns exactly one byte address. Six four-bit configuration banks sit behind that address. A command bit in every written byte decides what the byte does. It either moves the pin's bank pointer or loads one bank. A read returns the bank that the pointer currently names.

Two of the banks steer hardware. Bank 1 holds the mode, the open-drain enable and the output value. The disable flag in bank 3 can hold the driver off. The block drives each pad's output enable and output value and reports whether open-drain is on. It registers the pad input levels into a real-time status vector. It also gives each pin a logical level: the programmed value when the pin is an output, and the sampled pad level in every other mode. The other fields are stored only so software can read them back: supply select, pull, drive strength, function and interrupt polarity.

Top module: `pincfg_bank_file`

## Requirements
- R1: Pin n answers at byte address BASE_ADDR + n (default 0x150). A write to any other address changes nothing. A read of any other address returns 0x00.
- R2: A written byte with bit 7 clear copies bits 6:4 into that pin's bank pointer. It leaves every bank's contents unchanged.
- R3: A written byte with bit 7 set copies bits 3:0 into the bank named by bits 6:4. It leaves the bank pointer unchanged.
- R4: When the read strobe is high at a clock edge, the data from that edge onward is {0, pointer[2:0], selected bank[3:0]}.
- R5: A written byte whose bank index (bits 6:4) is 6 or 7 is ignored entirely, whatever bit 7 holds.
- R6: Synchronous active-low reset clears every bank, every pointer, the read data and the status vector. All output enables are then low.
- R7: The output enable is high only when two conditions hold. The bank 1 mode (bits 3:2) must be 1 (in/out) or 2 (out); mode 0 is input and mode 3 is off. The bank 3 disable flag (bit 0) must also be clear.
- R8: When the bank 1 open-drain bit (bit 1) is clear, the pad output equals the bank 1 value bit (bit 0). When it is set, the pad output is 0 and the enable drops while the value bit is 1.
- R9: A pin's level equals the bank 1 value bit in mode 2. In every other mode it equals that pin's real-time status bit.
- R10: The real-time status vector equals the pad input vector as it stood one clock edge earlier.
- R11: Six consecutive flagged writes to one address, one per bank index 0 to 5, load all six banks. Each bank can then be read back by selecting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte (bit 7 command, 6:4 bank index, 3:0 payload) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output values |
| pad_od | output | NUM_PINS | Open-drain selected per pin |
| rt_status | output | NUM_PINS | Registered pad input levels |
| pin_level | output | NUM_PINS | Logical level per pin |

## Verification
The hardest case to reach is a pointer that disagrees with the bank just written. From the ports a flagged write and a later read look alike, whether or not the write also moved the pointer. To expose the difference, the stimulus first selects one bank and then loads a different bank through a flagged write. The read that follows must return the first bank's contents. The same sequence is repeated with bank indices 6 and 7, which must leave both the pointer and the contents as they were. The pin-level mux is exercised by programming an output value opposite to the pad level and then switching the mode.

// File: rtl/pincfg_pkg.sv
// Package: shared constants and the mode encoding for the pin configuration
// register file. Assumes four payload bits per bank and an 8-bit bus.
package pincfg_pkg;
    localparam int NUM_BANKS = 6;
    localparam int BIDX_W    = 3;
    localparam int PAY_W     = 4;
    localparam int DATA_W    = 8;
    localparam int CMD_BIT   = 7;

    typedef enum logic [1:0] {
        MODE_IN    = 2'd0,
        MODE_INOUT = 2'd1,
        MODE_OUT   = 2'd2,
        MODE_OFF   = 2'd3
    } pin_mode_e;

    localparam logic [BIDX_W-1:0] BANK_CTRL = 3'd1;
    localparam logic [BIDX_W-1:0] BANK_DRV  = 3'd3;
endpackage

// File: rtl/pincfg_decode.sv
// Module: pincfg_decode
// Maps a bus address onto a pin index. Assumes the pin window
// [BASE_ADDR, BASE_ADDR+NUM_PINS) fits inside ADDR_W bits.
module pincfg_decode #(
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h150,
    parameter int NUM_PINS  = 8,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PIN_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR + NUM_PINS);

    logic [ADDR_W-1:0] offs;

    // Range test and offset inside the pin window.
    always_comb begin
        hit  = (addr >= LO) && (addr < HI);
        offs = addr - LO;
        idx  = offs[PIN_W-1:0];
    end
endmodule

// File: rtl/pincfg_pin.sv
// Module: pincfg_pin
// Holds the six banks and the bank pointer of one pin and derives its pad
// controls. Assumes wr is already qualified by the address decode.
module pincfg_pin
    import pincfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    pad_in,
    output logic [BIDX_W-1:0]       ptr,
    output logic [PAY_W-1:0]        sel_bank,
    output logic                    oe,
    output logic                    out,
    output logic                    od,
    output logic                    rt,
    output logic                    level
);
    logic [NUM_BANKS-1:0][PAY_W-1:0] bank_q;
    logic [BIDX_W-1:0]               ptr_q;
    logic                            rt_q;
    logic [BIDX_W-1:0]               w_idx;
    logic                            w_ok;
    pin_mode_e                       mode;
    logic                            val, dis;

    assign w_idx = wdata[6:4];
    assign w_ok  = (w_idx < BIDX_W'(NUM_BANKS));

    // Bank loads on flagged writes to a valid index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr && wdata[CMD_BIT] && w_ok) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (w_idx == BIDX_W'(b)) bank_q[b] <= wdata[PAY_W-1:0];
            end
        end
    end

    // Pointer moves on unflagged writes to a valid index.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ptr_q <= '0;
        else if (wr && !wdata[CMD_BIT] && w_ok)  ptr_q <= w_idx;
    end

    // Real-time status sample of the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= 1'b0;
        else        rt_q <= pad_in;
    end

    // Selected-bank read mux.
    always_comb begin
        sel_bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ptr_q == BIDX_W'(b)) sel_bank = bank_q[b];
        end
    end

    // Pad control from bank 1 and the bank 3 disable flag.
    always_comb begin
        mode  = pin_mode_e'(bank_q[BANK_CTRL][3:2]);
        od    = bank_q[BANK_CTRL][1];
        val   = bank_q[BANK_CTRL][0];
        dis   = bank_q[BANK_DRV][0];
        oe    = ((mode == MODE_INOUT) || (mode == MODE_OUT)) && !dis && !(od && val);
        out   = val && !od;
        level = (mode == MODE_OUT) ? val : rt_q;
    end

    assign ptr = ptr_q;
    assign rt  = rt_q;

    // R3
    cmd_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[CMD_BIT]) |=> $stable(ptr_q));
    // R2
    sel_keeps_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[CMD_BIT]) |=> $stable(bank_q));
    // R5
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata[6:4] > 3'd5)) |=> ($stable(bank_q) && $stable(ptr_q)));
    // R10
    rt_follows_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rt == $past(pad_in)));
endmodule

// File: rtl/pincfg_bank_file.sv
// Module: pincfg_bank_file
// Top of the banked pin configuration register file: decodes the bus,
// fans writes out to one pincfg_pin per pin and registers read data.
// Assumes one access per cycle; a read in the same cycle as a write sees
// the state from before the write.
module pincfg_bank_file
    import pincfg_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h150
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   rt_status,
    output logic [NUM_PINS-1:0]   pin_level
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic              hit;
    logic [PIN_W-1:0]  idx;
    logic [BIDX_W-1:0] ptr_w [NUM_PINS];
    logic [PAY_W-1:0]  nib_w [NUM_PINS];
    logic [DATA_W-1:0] rd_next;

    pincfg_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_PINS(NUM_PINS)
    ) u_dec (
        .addr(bus_addr), .hit(hit), .idx(idx)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic wr_p;
        assign wr_p = bus_we && hit && (idx == PIN_W'(p));
        pincfg_pin u_pin (
            .clk(clk), .rst_n(rst_n), .wr(wr_p), .wdata(bus_wdata),
            .pad_in(pad_in[p]), .ptr(ptr_w[p]), .sel_bank(nib_w[p]),
            .oe(pad_oe[p]), .out(pad_out[p]), .od(pad_od[p]),
            .rt(rt_status[p]), .level(pin_level[p])
        );
    end

    // Read word for the addressed pin, zero outside the window.
    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (hit && (idx == PIN_W'(p))) rd_next = {1'b0, ptr_w[p], nib_w[p]};
        end
    end

    // Read data register, updated on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end

    // R1
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !hit) |=> (bus_rdata == '0));
    // R4
    rdata_cmd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_rdata[CMD_BIT]);
endmodule

// File: tb/sim_pincfg_bank_file.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module sim_pincfg_bank_file;
    localparam int N = 8;
    localparam int AW = 10;
    localparam int BASE = 'h150;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_oe, pad_out, pad_od, rt_status, pin_level;

    int errors = 0, checks = 0;
    logic re_seen = 1'b0;
    logic done = 1'b0;

    typedef struct { logic [7:0] exp; string req; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    pincfg_bank_file #(.NUM_PINS(N), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .rt_status(rt_status), .pin_level(pin_level)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int pin, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(BASE + pin); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_abs(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_abs(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        e.exp = exp; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd(input int pin, input logic [7:0] exp, input string req);
        rd_abs(AW'(BASE + pin), exp, req);
    endtask

    // Marks that a read strobe was taken at the last edge.
    always @(posedge clk) re_seen <= bus_re;

    // Monitor: pops one expectation per completed read.
    always @(negedge clk) begin
        if (re_seen) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected read", 32'(bus_rdata), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(bus_rdata == e.exp, e.req, 32'(bus_rdata), 32'(e.exp));
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [3:0] VAL [6] = '{4'h5, 4'h9, 4'h6, 4'h8, 4'hA, 4'h8};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check(pad_oe == '0, "R6 oe after reset", 32'(pad_oe), 0);
        rd(0, 8'h00, "R6 pin0 read after reset");
        rd(5, 8'h00, "R6 pin5 read after reset");

        // R11 load all six banks of pin 2
        for (int b = 0; b < 6; b++) wr(2, 8'h80 | 8'(b << 4) | 8'(VAL[b]));
        // R2 R4 select each bank and read it back
        for (int b = 0; b < 6; b++) begin
            wr(2, 8'(b << 4));
            rd(2, 8'(b << 4) | 8'(VAL[b]), "R11 bank readback");
        end
        // R7 R8 R9 pin2 output mode, value 1, push-pull
        check(pad_oe == 8'h04, "R7 oe pin2 out mode", 32'(pad_oe), 32'h04);
        check(pad_out[2] == 1'b1, "R8 push-pull value", 32'(pad_out[2]), 1);
        check(pin_level[2] == 1'b1, "R9 level from value in mode 2", 32'(pin_level[2]), 1);

        // R3 flagged write keeps pointer
        wr(2, 8'h20);
        wr(2, 8'hC3);
        rd(2, 8'h26, "R3 pointer kept after flagged write");
        wr(2, 8'h40);
        rd(2, 8'h43, "R3 flagged write landed in bank 4");

        // R5 bank indices 6 and 7 ignored
        wr(2, 8'hE5);
        wr(2, 8'h70);
        wr(2, 8'hF1);
        rd(2, 8'h43, "R5 index 6/7 ignored");
        wr(2, 8'h10);
        rd(2, 8'h19, "R5 bank1 untouched");

        // R1 out-of-range
        wr_abs(AW'(BASE + N), 8'h99);
        wr_abs(AW'(BASE - 1), 8'h99);
        rd_abs(AW'(BASE + N), 8'h00, "R1 read above window");
        rd_abs(AW'(BASE - 1), 8'h00, "R1 read below window");
        wr(7, 8'h10);
        rd(7, 8'h10, "R1 pin7 bank1 untouched");
        check(pad_oe == 8'h04, "R1 no stray enables", 32'(pad_oe), 32'h04);

        // R8 open drain
        wr(2, 8'h9B);
        check(pad_oe[2] == 1'b0 && pad_out[2] == 1'b0, "R8 od high releases", 32'({pad_oe[2], pad_out[2]}), 0);
        check(pad_od[2] == 1'b1, "R8 od flag", 32'(pad_od[2]), 1);
        wr(2, 8'h9A);
        check(pad_oe[2] == 1'b1 && pad_out[2] == 1'b0, "R8 od low drives", 32'({pad_oe[2], pad_out[2]}), 32'h2);

        // R7 disable flag and modes
        wr(2, 8'h99);
        wr(2, 8'hB1);
        check(pad_oe[2] == 1'b0, "R7 disabled pin", 32'(pad_oe[2]), 0);
        wr(2, 8'hB0);
        check(pad_oe[2] == 1'b1, "R7 re-enabled pin", 32'(pad_oe[2]), 1);
        wr(2, 8'h9D);
        check(pad_oe[2] == 1'b0, "R7 mode off", 32'(pad_oe[2]), 0);
        wr(2, 8'h95);
        check(pad_oe[2] == 1'b1, "R7 mode in/out", 32'(pad_oe[2]), 1);

        // R9 R10 input mode uses sampled pad
        wr(2, 8'h91);
        check(pad_oe[2] == 1'b0, "R7 mode in", 32'(pad_oe[2]), 0);
        check(pin_level[2] == 1'b0, "R9 level from status, not value", 32'(pin_level[2]), 0);
        pad_in = 8'h24;
        @(negedge clk);
        check(rt_status == 8'h24, "R10 status one edge later", 32'(rt_status), 32'h24);
        check(pin_level[2] == 1'b1, "R9 level follows pad", 32'(pin_level[2]), 1);
        pad_in = 8'h00;
        @(negedge clk);
        check(rt_status == 8'h00, "R10 status clears", 32'(rt_status), 0);

        // R6 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(pad_oe == '0 && rt_status == '0, "R6 outputs after reset", 32'({pad_oe, rt_status}), 0);
        rd(2, 8'h00, "R6 pin2 cleared");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R4 all reads returned", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule